// File: doc/BRIEF.md
# Host Port Resource Decoder

This block decodes the control lines of the host-side port of a bidirectional two-direction buffer. The host drives an active-low chip-select, a 3-bit address, a read/write line (1 = read, 0 = write), an active-low enable and an active-low output enable, all sampled on the port clock. From these the decoder issues strobes to an external outbound FIFO, an external inbound FIFO and an external bypass path. It also owns four 9-bit threshold offset registers that the flag logic of the two FIFOs consumes.

Every read loads the selected resource into a registered 18-bit output. The bidirectional bus is split into `bus_in`, `bus_out` and a drive enable `bus_oe`. After any clock edge that sampled a write, the bus is kept off until an edge samples read again, so the host and the block never fight on the wires. A reset only takes effect when the reset line is low while chip-select and both port enables are high.

The FIFOs act on strobes in the same clock edge that the decoder samples. Back-to-back reads therefore return successive words.

Top module: `host_port_decoder`

## Requirements
- R1: While `cs_n` is 1, `bus_oe` is 0 and none of `ob_push`, `ib_pop`, `byp_push`, `byp_pop` is asserted, whatever the other inputs are.
- R2: With `cs_n`=0, `en_n`=0 and `addr`=3'b000: a write (`rd_wr`=0) asserts `ob_push` in that cycle with `wr_data` equal to `bus_in`; a read (`rd_wr`=1) asserts `ib_pop` in that cycle, and `bus_out` equals the `ib_head` value sampled at that clock edge after the edge.
- R3: With `cs_n`=0, `en_n`=0 and `addr`=3'b001: a write asserts `byp_push` with `wr_data` equal to `bus_in`; a read asserts `byp_pop` and loads `byp_head` into `bus_out` at the edge. Neither FIFO strobe is asserted.
- R4: A write with `cs_n`=0 and `en_n`=0 at address 3'b100, 3'b101, 3'b110 or 3'b111 stores `bus_in[8:0]` at the edge into `off_ob_ae`, `off_ob_af`, `off_ib_ae` or `off_ib_af` respectively. The other three offsets are unchanged.
- R5: A read at an offset address loads that offset into `bus_out[8:0]` at the edge, with `bus_out[17:9]` zero.
- R6: While `en_n` is 1, no strobe is asserted, `bus_out` keeps its value across the edge and no offset changes.
- R7: `bus_oe` is 1 only while `cs_n`=0, `rd_wr`=1 and `oe_n`=0, and is 1 under those conditions when the previous edge sampled `rd_wr`=1.
- R8: After a clock edge that sampled `rd_wr`=0, `bus_oe` stays 0 until an edge samples `rd_wr`=1, even while `oe_n`=0 and `rd_wr`=1.
- R9: An edge with `rst_n`=0 and `cs_n`, `en_n`, `far_en_n` all 1 sets all four offsets to 8, `bus_out` to 0 and `bus_oe` to 0. With `rst_n`=0 while any of those three is 0, the edge does not reset.
- R10: Addresses 3'b010 and 3'b011 select nothing. A write there asserts no strobe and changes no offset; a read asserts no strobe and loads 0 into `bus_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Reset request, active low, qualified |
| far_en_n | input | 1 | Enable of the opposite port, used only to qualify reset |
| cs_n | input | 1 | Chip-select, active low |
| addr | input | 3 | Resource address |
| rd_wr | input | 1 | 1 = read, 0 = write |
| en_n | input | 1 | Transfer enable, active low |
| oe_n | input | 1 | Output enable, active low |
| bus_in | input | 18 | Data arriving from the host bus |
| bus_out | output | 18 | Output register value |
| bus_oe | output | 1 | Drive enable for the host bus |
| wr_data | output | 18 | Write data to the outbound FIFO and the bypass path |
| ob_push | output | 1 | Write strobe to the outbound FIFO |
| ib_pop | output | 1 | Pop strobe to the inbound FIFO |
| ib_head | input | 18 | Head word of the inbound FIFO |
| byp_push | output | 1 | Write strobe to the outbound bypass register |
| byp_pop | output | 1 | Read strobe to the inbound bypass register |
| byp_head | input | 18 | Word held in the inbound bypass register |
| off_ob_ae | output | 9 | Outbound almost-empty offset |
| off_ob_af | output | 9 | Outbound almost-full offset |
| off_ib_ae | output | 9 | Inbound almost-empty offset |
| off_ib_af | output | 9 | Inbound almost-full offset |

## Verification
A wrong address decode shows at once as a strobe on the wrong port in the same cycle. It also shows one edge later as the wrong word in `bus_out`, since every read copies the selected resource there. A corrupted offset register shows on its offset port right after the edge and again in `bus_out` on the next read of that address. A stuck bus-direction flag shows as `bus_oe` rising one cycle too early after a write, or never rising at all.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

    localparam int OFF_COUNT = 4;
    localparam int IDX_W     = $clog2(OFF_COUNT);

    typedef enum logic [1:0] {
        RES_FIFO = 2'd0,
        RES_BYP  = 2'd1,
        RES_OFF  = 2'd2,
        RES_NONE = 2'd3
    } res_e;

    typedef struct packed {
        res_e             res;
        logic [IDX_W-1:0] idx;
        logic             wr_go;
        logic             rd_go;
    } cmd_t;

endpackage

// File: rtl/hpd_cmd_decode.sv
module hpd_cmd_decode
    import hpd_pkg::*;
(
    input  logic       cs_n,
    input  logic [2:0] addr,
    input  logic       rd_wr,
    input  logic       en_n,
    output cmd_t       cmd
);

    logic active;

    always_comb begin
        active    = ~cs_n & ~en_n;
        cmd       = '0;
        cmd.wr_go = active & ~rd_wr;
        cmd.rd_go = active & rd_wr;
        cmd.idx   = addr[IDX_W-1:0];
        casez (addr)
            3'b000:  cmd.res = RES_FIFO;
            3'b001:  cmd.res = RES_BYP;
            3'b1??:  cmd.res = RES_OFF;
            default: cmd.res = RES_NONE;
        endcase
    end

endmodule

// File: rtl/hpd_offset_bank.sv
module hpd_offset_bank
    import hpd_pkg::*;
#(
    parameter int OFF_W   = 9,
    parameter int OFF_RST = 8
) (
    input  logic                             clk,
    input  logic                             clr,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [OFF_W-1:0]                 wdata,
    output logic [OFF_COUNT-1:0][OFF_W-1:0]  offs
);

    for (genvar g = 0; g < OFF_COUNT; g++) begin : g_off
        logic [OFF_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (clr) begin
                val_d = OFF_W'(OFF_RST);
            end else if (we && (idx == IDX_W'(g))) begin
                val_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            val_q <= val_d;
        end

        assign offs[g] = val_q;
    end

endmodule

// File: rtl/hpd_out_stage.sv
module hpd_out_stage
    import hpd_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int OFF_W  = 9
) (
    input  logic                             clk,
    input  logic                             clr,
    input  cmd_t                             cmd,
    input  logic                             cs_n,
    input  logic                             rd_wr,
    input  logic                             oe_n,
    input  logic [DATA_W-1:0]                ib_head,
    input  logic [DATA_W-1:0]                byp_head,
    input  logic [OFF_COUNT-1:0][OFF_W-1:0]  offs,
    output logic [DATA_W-1:0]                bus_out,
    output logic                             bus_oe
);

    typedef struct packed {
        logic [DATA_W-1:0] out;
        logic              dir;
    } st_t;

    st_t               st_d, st_q;
    logic [DATA_W-1:0] sel;

    always_comb begin
        case (cmd.res)
            RES_FIFO: sel = ib_head;
            RES_BYP:  sel = byp_head;
            RES_OFF:  sel = DATA_W'(offs[cmd.idx]);
            default:  sel = '0;
        endcase

        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (cmd.rd_go) begin
                st_d.out = sel;
            end
            st_d.dir = rd_wr;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bus_out = st_q.out;
    assign bus_oe  = ~cs_n & rd_wr & ~oe_n & st_q.dir;

endmodule

// File: rtl/host_port_decoder.sv
module host_port_decoder
    import hpd_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int OFF_W   = 9,
    parameter int OFF_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              far_en_n,
    input  logic              cs_n,
    input  logic [2:0]        addr,
    input  logic              rd_wr,
    input  logic              en_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] wr_data,
    output logic              ob_push,
    output logic              ib_pop,
    input  logic [DATA_W-1:0] ib_head,
    output logic              byp_push,
    output logic              byp_pop,
    input  logic [DATA_W-1:0] byp_head,
    output logic [OFF_W-1:0]  off_ob_ae,
    output logic [OFF_W-1:0]  off_ob_af,
    output logic [OFF_W-1:0]  off_ib_ae,
    output logic [OFF_W-1:0]  off_ib_af
);

    cmd_t                            cmd;
    logic                            clr;
    logic [OFF_COUNT-1:0][OFF_W-1:0] offs;

    assign clr = ~rst_n & cs_n & en_n & far_en_n;

    hpd_cmd_decode i_dec (
        .cs_n  (cs_n),
        .addr  (addr),
        .rd_wr (rd_wr),
        .en_n  (en_n),
        .cmd   (cmd)
    );

    hpd_offset_bank #(
        .OFF_W   (OFF_W),
        .OFF_RST (OFF_RST)
    ) i_bank (
        .clk   (clk),
        .clr   (clr),
        .we    (cmd.wr_go && (cmd.res == RES_OFF)),
        .idx   (cmd.idx),
        .wdata (bus_in[OFF_W-1:0]),
        .offs  (offs)
    );

    hpd_out_stage #(
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W)
    ) i_out (
        .clk      (clk),
        .clr      (clr),
        .cmd      (cmd),
        .cs_n     (cs_n),
        .rd_wr    (rd_wr),
        .oe_n     (oe_n),
        .ib_head  (ib_head),
        .byp_head (byp_head),
        .offs     (offs),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe)
    );

    assign wr_data  = bus_in;
    assign ob_push  = cmd.wr_go && (cmd.res == RES_FIFO);
    assign ib_pop   = cmd.rd_go && (cmd.res == RES_FIFO);
    assign byp_push = cmd.wr_go && (cmd.res == RES_BYP);
    assign byp_pop  = cmd.rd_go && (cmd.res == RES_BYP);

    assign off_ob_ae = offs[0];
    assign off_ob_af = offs[1];
    assign off_ib_ae = offs[2];
    assign off_ib_af = offs[3];

endmodule

// File: rtl/hpd_checker.sv
module hpd_checker #(
    parameter int DATA_W  = 18,
    parameter int OFF_W   = 9,
    parameter int OFF_RST = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              far_en_n,
    input logic              cs_n,
    input logic [2:0]        addr,
    input logic              rd_wr,
    input logic              en_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] bus_in,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_oe,
    input logic              ob_push,
    input logic              ib_pop,
    input logic [DATA_W-1:0] ib_head,
    input logic              byp_push,
    input logic              byp_pop,
    input logic [DATA_W-1:0] byp_head,
    input logic [OFF_W-1:0]  off_ob_ae,
    input logic [OFF_W-1:0]  off_ob_af,
    input logic [OFF_W-1:0]  off_ib_ae,
    input logic [OFF_W-1:0]  off_ib_af
);

    logic rst_hit;
    logic armed_q;

    assign rst_hit = !rst_n && cs_n && en_n && far_en_n;

    always_ff @(posedge clk) begin
        if (rst_hit) begin
            armed_q <= 1'b1;
        end
    end

    // R1
    cs_idle_chk: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        cs_n |-> (!bus_oe && !ob_push && !ib_pop && !byp_push && !byp_pop));

    // R2
    pop_load_chk: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        ib_pop |=> (bus_out == $past(ib_head)));

    // R3
    byp_load_chk: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        byp_pop |=> (bus_out == $past(byp_head)));

    // R4
    off_wr_chk: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (!cs_n && !en_n && !rd_wr && addr == 3'b100) |=> (off_ob_ae == OFF_W'($past(bus_in))));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (en_n && !rst_hit) |=> $stable(bus_out));

    // R7
    drive_chk: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        bus_oe |-> (!cs_n && rd_wr && !oe_n));

    // R8
    turn_chk: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        bus_oe |-> $past(rd_wr));

    // R9
    reset_chk: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        rst_hit |=> (off_ob_ae == OFF_W'(OFF_RST) && off_ob_af == OFF_W'(OFF_RST) &&
                     off_ib_ae == OFF_W'(OFF_RST) && off_ib_af == OFF_W'(OFF_RST) &&
                     bus_out == '0));

endmodule

bind host_port_decoder hpd_checker #(
    .DATA_W  (DATA_W),
    .OFF_W   (OFF_W),
    .OFF_RST (OFF_RST)
) i_chk (.*);

// File: tb/test_host_port_decoder.sv
`timescale 1ns/1ps
module test_host_port_decoder;

    logic        clk = 1'b0;
    logic        rst_n, far_en_n, cs_n, rd_wr, en_n, oe_n;
    logic [2:0]  addr;
    logic [17:0] bus_in, bus_out, wr_data, ib_head, byp_head;
    logic        bus_oe, ob_push, ib_pop, byp_push, byp_pop;
    logic [8:0]  off_ob_ae, off_ob_af, off_ib_ae, off_ib_af;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [8:0] exp_off [4];

    always #2 clk = ~clk;

    host_port_decoder i_host_port_decoder (
        .clk(clk), .rst_n(rst_n), .far_en_n(far_en_n), .cs_n(cs_n), .addr(addr),
        .rd_wr(rd_wr), .en_n(en_n), .oe_n(oe_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .wr_data(wr_data), .ob_push(ob_push), .ib_pop(ib_pop),
        .ib_head(ib_head), .byp_push(byp_push), .byp_pop(byp_pop), .byp_head(byp_head),
        .off_ob_ae(off_ob_ae), .off_ob_af(off_ob_af), .off_ib_ae(off_ib_ae),
        .off_ib_af(off_ib_af)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drv(input logic c, input logic [2:0] a, input logic rw,
                       input logic e, input logic o, input logic [17:0] d);
        @(negedge clk);
        cs_n = c; addr = a; rd_wr = rw; en_n = e; oe_n = o; bus_in = d;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_offs(input string req);
        chk(req, "off_ob_ae", 32'(off_ob_ae), 32'(exp_off[0]));
        chk(req, "off_ob_af", 32'(off_ob_af), 32'(exp_off[1]));
        chk(req, "off_ib_ae", 32'(off_ib_ae), 32'(exp_off[2]));
        chk(req, "off_ib_af", 32'(off_ib_af), 32'(exp_off[3]));
    endtask

    task automatic do_reset();
        drv(1, 3'b000, 1, 1, 1, '0);
        rst_n = 1'b0;
        tick(); tick();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) exp_off[i] = 9'd8;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9", "offsets after reset", 32'(off_ob_ae + off_ob_af + off_ib_ae + off_ib_af), 32'd32);
        chk_offs("R9");
        chk("R9", "bus_out after reset", 32'(bus_out), 32'h0);
        chk("R9", "bus_oe after reset", 32'(bus_oe), 32'h0);
    endtask

    task automatic t_fifo();
        drv(0, 3'b000, 0, 0, 1, 18'h12345);
        chk("R2", "ob_push on write", 32'(ob_push), 32'h1);
        chk("R2", "wr_data", 32'(wr_data), 32'h12345);
        chk("R2", "ib_pop on write", 32'(ib_pop), 32'h0);
        chk("R2", "byp_push on fifo write", 32'(byp_push), 32'h0);
        tick();
        ib_head = 18'h2AAAA;
        drv(0, 3'b000, 1, 0, 0, '0);
        chk("R2", "ib_pop on read", 32'(ib_pop), 32'h1);
        chk("R2", "ob_push on read", 32'(ob_push), 32'h0);
        chk("R8", "bus_oe right after write edge", 32'(bus_oe), 32'h0);
        tick();
        chk("R2", "bus_out first pop", 32'(bus_out), 32'h2AAAA);
        chk("R7", "bus_oe after read edge", 32'(bus_oe), 32'h1);
        ib_head = 18'h01357;
        drv(0, 3'b000, 1, 0, 0, '0);
        tick();
        chk("R2", "bus_out second pop", 32'(bus_out), 32'h01357);
    endtask

    task automatic t_bypass();
        drv(0, 3'b001, 0, 0, 1, 18'h30F0F);
        chk("R3", "byp_push", 32'(byp_push), 32'h1);
        chk("R3", "wr_data bypass", 32'(wr_data), 32'h30F0F);
        chk("R3", "ob_push in bypass", 32'(ob_push), 32'h0);
        tick();
        byp_head = 18'h15A5A;
        ib_head  = 18'h3FFFF;
        drv(0, 3'b001, 1, 0, 1, '0);
        chk("R3", "byp_pop", 32'(byp_pop), 32'h1);
        chk("R3", "ib_pop in bypass", 32'(ib_pop), 32'h0);
        tick();
        chk("R3", "bus_out bypass", 32'(bus_out), 32'h15A5A);
    endtask

    task automatic t_offsets();
        logic [8:0] vals [4];
        vals[0] = 9'h003; vals[1] = 9'h1F0; vals[2] = 9'h055; vals[3] = 9'h100;
        for (int i = 0; i < 4; i++) begin
            drv(0, 3'(4 + i), 0, 0, 1, {9'h1FF, vals[i]});
            chk("R4", "no strobe on offset write", 32'(ob_push | byp_push), 32'h0);
            tick();
            exp_off[i] = vals[i];
            chk_offs("R4");
        end
        for (int i = 0; i < 4; i++) begin
            drv(0, 3'(4 + i), 1, 0, 1, '0);
            tick();
            chk("R5", "offset readback zero-extended", 32'(bus_out), 32'(vals[i]));
        end
    endtask

    task automatic t_hold();
        logic [17:0] prev;
        prev    = bus_out;
        ib_head = 18'h0BEEF;
        drv(0, 3'b000, 1, 1, 1, '0);
        chk("R6", "ib_pop with en_n high", 32'(ib_pop), 32'h0);
        tick();
        chk("R6", "bus_out hold", 32'(bus_out), 32'(prev));
        drv(0, 3'b100, 0, 1, 1, 18'h000AA);
        chk("R6", "ob_push with en_n high", 32'(ob_push), 32'h0);
        tick();
        chk_offs("R6");
    endtask

    task automatic t_cs_idle();
        drv(1, 3'b000, 1, 0, 0, '0);
        chk("R1", "bus_oe deselected", 32'(bus_oe), 32'h0);
        chk("R1", "ib_pop deselected", 32'(ib_pop), 32'h0);
        drv(1, 3'b001, 0, 0, 0, 18'h11111);
        chk("R1", "strobes deselected", 32'({ob_push, ib_pop, byp_push, byp_pop}), 32'h0);
        tick();
        chk_offs("R1");
    endtask

    task automatic t_oe();
        drv(0, 3'b000, 1, 1, 1, '0);
        tick();
        chk("R7", "bus_oe with oe_n high", 32'(bus_oe), 32'h0);
        oe_n = 1'b0;
        #1;
        chk("R7", "bus_oe with oe_n low", 32'(bus_oe), 32'h1);
        rd_wr = 1'b0;
        #1;
        chk("R7", "bus_oe with rd_wr low", 32'(bus_oe), 32'h0);
        tick();
        rd_wr = 1'b1;
        #1;
        chk("R8", "bus_oe held off after write edge", 32'(bus_oe), 32'h0);
        tick();
        chk("R8", "bus_oe back after read edge", 32'(bus_oe), 32'h1);
    endtask

    task automatic t_undef();
        drv(0, 3'b000, 1, 0, 1, '0);
        ib_head = 18'h2468A;
        tick();
        drv(0, 3'b010, 0, 0, 1, 18'h1FFFF);
        chk("R10", "strobes at 010 write", 32'({ob_push, ib_pop, byp_push, byp_pop}), 32'h0);
        tick();
        chk_offs("R10");
        drv(0, 3'b011, 1, 0, 1, '0);
        chk("R10", "strobes at 011 read", 32'({ob_push, ib_pop, byp_push, byp_pop}), 32'h0);
        tick();
        chk("R10", "bus_out at 011 read", 32'(bus_out), 32'h0);
    endtask

    task automatic t_reset_qual();
        drv(0, 3'b000, 1, 1, 1, '0);
        rst_n = 1'b0;
        tick();
        chk_offs("R9");
        drv(1, 3'b000, 1, 1, 1, '0);
        far_en_n = 1'b0;
        tick();
        chk("R9", "no reset with far_en_n low", 32'(off_ib_af), 32'(exp_off[3]));
        @(negedge clk);
        far_en_n = 1'b1;
        tick();
        for (int i = 0; i < 4; i++) exp_off[i] = 9'd8;
        chk_offs("R9");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; far_en_n = 1'b1; cs_n = 1'b1; addr = '0; rd_wr = 1'b1;
        en_n = 1'b1; oe_n = 1'b1; bus_in = '0; ib_head = '0; byp_head = '0;
        t_reset();
        t_fifo();
        t_bypass();
        t_offsets();
        t_hold();
        t_cs_idle();
        t_oe();
        t_undef();
        t_reset_qual();
        repeat (2) tick();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule